// File: doc/BRIEF.md
# Streaming GF(2) Matrix-Vector Engine

The engine forms dot products over GF(2) between one stored matrix row and each vector of a stream of `M` vectors, each `N` elements long. A row is first written into an internal row register with a load command. A compute command then takes the vectors column by column: element 0 of every vector, then element 1 of every vector, and so on. Each incoming bit is ANDed with the matching row coefficient. The product is XORed into that vector's running sum, which circulates through an `M`-deep delay line. After the last column the `M` finished sums leave the block one per cycle, in vector order.

The delay line is seeded when column 0 enters. The seed is zero, or a bit from an earlier stage when cascading is enabled. Several engines can therefore be chained so that each adds its row's contribution to a partial result from the previous one. One bit moves per accepted beat on a valid/ready input. Results carry a valid strobe.

Top module: `gf2_mv_engine`

## Requirements
- R1: After reset `data_ready_o` and `res_valid_o` are low and every row coefficient is 0.
- R2: Command codes on `cmd_i`: 2'b00 no operation, 2'b01 load row, 2'b10 compute, 2'b11 clear. A command is taken only while the block is idle. After a load or compute command is taken, `data_ready_o` is high in the next cycle.
- R3: In load mode the block accepts exactly `N` beats. Beat k writes coefficient k. The block then returns to idle.
- R4: In compute mode the block accepts exactly `M*N` beats. Beat number j*M+v carries element j of vector v.
- R5: The result for vector v is the XOR over j of (coefficient j AND element j of vector v).
- R6: If `casc_en_i` is high on the beat that carries element 0 of vector v, then `casc_data_i` from that beat is XORed into the result for vector v. Otherwise the seed for that vector is zero.
- R7: After the last compute beat, `res_valid_o` is high for exactly `M` consecutive cycles, starting in the next cycle. The results appear for vectors 0..M-1 in that order, and `data_ready_o` stays low during this burst.
- R8: A command presented while loading, computing or draining has no effect.
- R9: A clear command sets every row coefficient to 0.
- R10: The stored row stays in place across compute passes until the next load or clear.
- R11: A cycle with `data_valid_i` low consumes no element and does not advance the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Command code, sampled while idle |
| data_i | input | 1 | Row coefficient or vector element |
| data_valid_i | input | 1 | `data_i` is valid |
| data_ready_o | output | 1 | Block accepts a beat (load or compute mode) |
| casc_en_i | input | 1 | Seed from `casc_data_i` instead of zero |
| casc_data_i | input | 1 | Partial result from a preceding stage |
| res_o | output | 1 | Finished dot product |
| res_valid_o | output | 1 | `res_o` is valid |

## Verification
The assertions assume that `cmd_i` is a clean 2-bit code on every clocked cycle after reset. They also assume that `data_valid_i` is only meaningful while `data_ready_o` is high, so that a beat is exactly the AND of the two. The stimulus drives every input half a cycle away from the sampling edge. It holds `cmd_i` at the no-operation code except for a single cycle at idle, or on purpose during a compute pass to test R8. It never leaves a pass unfinished, so every compute pass reaches its drain burst.

// File: rtl/gf2_mv_pkg.sv
package gf2_mv_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_LOAD = 2'b01,
    CMD_COMP = 2'b10,
    CMD_CLR  = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_COMP,
    ST_DRAIN
  } state_e;
endpackage

// File: rtl/gf2_mv_ctrl.sv
module gf2_mv_ctrl
  import gf2_mv_pkg::*;
#(
  parameter int N  = 3,
  parameter int M  = 4,
  localparam int CW = (N > 1) ? $clog2(N) : 1,
  localparam int VW = (M > 1) ? $clog2(M) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    cmd_i,
  input  logic          data_valid_i,
  output logic          ready_o,
  output logic          drain_o,
  output logic          load_we_o,
  output logic          comp_we_o,
  output logic          clr_o,
  output logic [CW-1:0] col_o,
  output logic          first_col_o
);
  state_e        state_q;
  logic [CW-1:0] col_q;
  logic [VW-1:0] vec_q;
  logic          beat;
  logic          last_col, last_vec;

  assign ready_o     = (state_q == ST_LOAD) || (state_q == ST_COMP);
  assign drain_o     = (state_q == ST_DRAIN);
  assign beat        = ready_o && data_valid_i;
  assign load_we_o   = beat && (state_q == ST_LOAD);
  assign comp_we_o   = beat && (state_q == ST_COMP);
  assign clr_o       = (state_q == ST_IDLE) && (cmd_e'(cmd_i) == CMD_CLR);
  assign col_o       = col_q;
  assign first_col_o = (col_q == '0);
  assign last_col    = (col_q == CW'(N - 1));
  assign last_vec    = (vec_q == VW'(M - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
      vec_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          col_q <= '0;
          vec_q <= '0;
          if (cmd_e'(cmd_i) == CMD_LOAD) state_q <= ST_LOAD;
          else if (cmd_e'(cmd_i) == CMD_COMP) state_q <= ST_COMP;
        end
        ST_LOAD: if (beat) begin
          if (last_col) begin
            col_q   <= '0;
            state_q <= ST_IDLE;
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
        ST_COMP: if (beat) begin
          if (last_vec) begin
            vec_q <= '0;
            if (last_col) begin
              col_q   <= '0;
              state_q <= ST_DRAIN;
            end else begin
              col_q <= col_q + 1'b1;
            end
          end else begin
            vec_q <= vec_q + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (last_vec) begin
            vec_q   <= '0;
            state_q <= ST_IDLE;
          end else begin
            vec_q <= vec_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gf2_mv_row_buf.sv
module gf2_mv_row_buf #(
  parameter int N  = 3,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [CW-1:0] idx_i,
  input  logic          bit_i,
  output logic [N-1:0]  row_o,
  output logic          coef_o
);
  logic [N-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_q <= '0;
    else if (clr_i) row_q <= '0;
    else if (we_i)  row_q[idx_i] <= bit_i;
  end

  assign row_o  = row_q;
  assign coef_o = row_q[idx_i];
endmodule

// File: rtl/gf2_mv_delay.sv
module gf2_mv_delay #(
  parameter int M = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_i,
  input  logic din_i,
  output logic head_o
);
  logic [M-1:0] dl_q;

  // dl_q[0] holds the oldest entry; new sums enter at the tail
  generate
    if (M == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      dl_q[0] <= 1'b0;
        else if (shift_i) dl_q[0] <= din_i;
      end
    end else begin : g_chain
      for (genvar i = 0; i < M - 1; i++) begin : g_tap
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)      dl_q[i] <= 1'b0;
          else if (shift_i) dl_q[i] <= dl_q[i+1];
        end
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      dl_q[M-1] <= 1'b0;
        else if (shift_i) dl_q[M-1] <= din_i;
      end
    end
  endgenerate

  assign head_o = dl_q[0];
endmodule

// File: rtl/gf2_mv_engine.sv
module gf2_mv_engine #(
  parameter int N = 3,
  parameter int M = 4,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] cmd_i,
  input  logic       data_i,
  input  logic       data_valid_i,
  output logic       data_ready_o,
  input  logic       casc_en_i,
  input  logic       casc_data_i,
  output logic       res_o,
  output logic       res_valid_o
);
  logic          drain, load_we, comp_we, clr, first_col;
  logic [CW-1:0] col;
  logic [N-1:0]  row_q;
  logic          coef, head, seed, sum;

  gf2_mv_ctrl #(.N(N), .M(M)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd_i),
    .data_valid_i(data_valid_i),
    .ready_o     (data_ready_o),
    .drain_o     (drain),
    .load_we_o   (load_we),
    .comp_we_o   (comp_we),
    .clr_o       (clr),
    .col_o       (col),
    .first_col_o (first_col)
  );

  gf2_mv_row_buf #(.N(N)) u_row (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .we_i  (load_we),
    .idx_i (col),
    .bit_i (data_i),
    .row_o (row_q),
    .coef_o(coef)
  );

  // column 0 starts a fresh sum: zero or the upstream partial result
  assign seed = first_col ? (casc_en_i & casc_data_i) : head;
  assign sum  = seed ^ (coef & data_i);

  gf2_mv_delay #(.M(M)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(comp_we | drain),
    .din_i  (drain ? 1'b0 : sum),
    .head_o (head)
  );

  assign res_o       = drain & head;
  assign res_valid_o = drain;
endmodule

// File: rtl/gf2_mv_engine_chk.sv
module gf2_mv_engine_chk #(
  parameter int N = 3,
  parameter int M = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [1:0]   cmd_i,
  input logic         data_valid_i,
  input logic         data_ready_o,
  input logic         res_valid_o,
  input logic [N-1:0] row_q
);
  localparam int BW = $clog2(M + 1) + 1;
  logic [BW-1:0] burst_q;
  logic          idle;

  assign idle = !data_ready_o && !res_valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          burst_q <= '0;
    else if (res_valid_o) burst_q <= burst_q + 1'b1;
    else                  burst_q <= '0;
  end

  a_r2_load_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && cmd_i == 2'b01) |=> data_ready_o);

  a_r2_comp_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && cmd_i == 2'b10) |=> data_ready_o);

  a_r9_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && cmd_i == 2'b11) |=> (row_q == '0));

  a_r7_no_ready_in_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !data_ready_o);

  a_r7_burst_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(res_valid_o) |-> (burst_q == BW'(M)));

  a_r7_drain_after_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(res_valid_o) |-> $past(data_valid_i && data_ready_o));
endmodule

bind gf2_mv_engine gf2_mv_engine_chk #(.N(N), .M(M)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_i       (cmd_i),
  .data_valid_i(data_valid_i),
  .data_ready_o(data_ready_o),
  .res_valid_o (res_valid_o),
  .row_q       (row_q)
);

// File: tb/gf2_mv_engine_tb.sv
`timescale 1ns/1ps
module gf2_mv_engine_tb;
  localparam int N = 3;
  localparam int M = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] cmd_i = 2'b00;
  logic       data_i = 1'b0;
  logic       data_valid_i = 1'b0;
  logic       casc_en_i = 1'b0;
  logic       casc_data_i = 1'b0;
  logic       data_ready_o, res_o, res_valid_o;

  int total = 0;
  int bad = 0;
  int popped = 0;
  bit done = 0;
  bit exp_q[$];
  string tag_q[$];
  logic [N-1:0] model_row = '0;

  always #2 clk_i = ~clk_i;

  gf2_mv_engine #(.N(N), .M(M)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd_i), .data_i(data_i),
    .data_valid_i(data_valid_i), .data_ready_o(data_ready_o),
    .casc_en_i(casc_en_i), .casc_data_i(casc_data_i),
    .res_o(res_o), .res_valid_o(res_valid_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compare each result against the scoreboard (R5, R6, R7)
  always @(negedge clk_i) begin
    if (rst_ni && res_valid_o) begin
      check(!data_ready_o, "R7 ready low in drain", data_ready_o, 0);
      if (exp_q.size() == 0) begin
        check(0, "R7 unexpected result", res_o, -1);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        popped++;
        check(res_o == e, t, res_o, e);
      end
    end
  end

  // caller is positioned just after a negative edge
  task automatic send_cmd(input logic [1:0] c);
    cmd_i = c;
    @(negedge clk_i);
    cmd_i = 2'b00;
  endtask

  task automatic load_row(input logic [N-1:0] row);
    send_cmd(2'b01);
    check(data_ready_o == 1'b1, "R2 ready after load cmd", data_ready_o, 1);
    for (int j = 0; j < N; j++) begin
      data_valid_i = 1'b1;
      data_i = row[j];
      @(negedge clk_i);
    end
    data_valid_i = 1'b0;
    check(data_ready_o == 1'b0, "R3 idle after N beats", data_ready_o, 0);
    model_row = row;
  endtask

  // vecs[v*N+j] is element j of vector v
  task automatic compute(input logic [M*N-1:0] vecs, input logic [M-1:0] casc,
                         input bit cen, input bit stall, input bit noise,
                         input string tag);
    for (int v = 0; v < M; v++) begin
      bit e;
      e = cen & casc[v];
      for (int j = 0; j < N; j++) e ^= model_row[j] & vecs[v*N+j];
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    popped = 0;
    send_cmd(2'b10);
    check(data_ready_o == 1'b1, "R2 ready after compute cmd", data_ready_o, 1);
    for (int j = 0; j < N; j++) begin
      for (int v = 0; v < M; v++) begin
        if (stall && ((j + v) % 2 == 0)) begin
          data_valid_i = 1'b0;
          data_i = 1'b1;
          casc_data_i = ~casc[v];
          @(negedge clk_i);
          check(res_valid_o == 1'b0, "R11 stall keeps stream", res_valid_o, 0);
        end
        data_valid_i = 1'b1;
        data_i = vecs[v*N+j];
        casc_en_i = cen;
        casc_data_i = (j == 0) ? casc[v] : ~casc[v];
        if (noise) cmd_i = 2'b11;
        @(negedge clk_i);
      end
    end
    data_valid_i = 1'b0;
    casc_en_i = 1'b0;
    cmd_i = 2'b00;
    check(res_valid_o == 1'b1, "R7 results start after last beat", res_valid_o, 1);
    repeat (M + 2) @(negedge clk_i);
    check(popped == M, "R7 burst length", popped, M);
    check(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(data_ready_o == 1'b0, "R1 ready after reset", data_ready_o, 0);
    check(res_valid_o == 1'b0, "R1 valid after reset", res_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compute(12'b101_110_011_111, 4'b0000, 0, 0, 0, "R1 zero row after reset");

    load_row(3'b101);
    compute(12'b001_100_111_010, 4'b0000, 0, 0, 0, "R5 row 101");
    compute(12'b110_101_011_100, 4'b0000, 0, 1, 0, "R10 row reused, R11 stalls");
    compute(12'b011_111_000_101, 4'b1010, 1, 0, 0, "R6 cascade seed");
    compute(12'b011_111_000_101, 4'b1111, 0, 0, 0, "R6 cascade disabled");

    load_row(3'b110);
    compute(12'b011_110_101_001, 4'b0110, 0, 0, 1, "R8 command ignored in compute");
    check(model_row == 3'b110, "R8 row kept", 0, 0);
    compute(12'b111_111_111_111, 4'b0000, 0, 0, 0, "R3 row 110 order");

    send_cmd(2'b11);
    model_row = '0;
    compute(12'b111_111_111_111, 4'b0000, 0, 0, 0, "R9 clear zeroes row");

    for (int r = 1; r < 8; r++) begin
      load_row(N'(r));
      compute(M*N'(r * 1237 + 91), M'(r), (r % 2) == 1, (r % 3) == 0, 0, "R5 sweep");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule